// File: doc/BRIEF.md
# Serial Management Master (MDC/MDIO)

This block is the master side of the two-wire PHY management bus. It makes the management clock from the host clock and moves 16-bit register values to and from a PHY over one bidirectional data line. The line is exposed as three separate pins (`mdio_out`, `mdio_oe`, `mdio_in`), so the pad cell stays outside the block.

A host register file sits in front of the block and drives three level requests: write a PHY register, read a PHY register, and scan. A scan reads one PHY register over and over. It also supplies the PHY and register addresses, the write value, the clock divider and a flag that drops the preamble. When a write or read frame really begins, the block pulses `wr_start` or `rd_start` for one cycle, and the host clears the matching request bit on that pulse. A scan request stays set until the host drops it. Each completed read or scan hands back the 16 read bits with a one-cycle capture strobe. Scanning the link register keeps `link_fail` current, and `scan_invalid` flags a scan whose first result has not come back yet.

Top module: `mdio_master`

## Requirements
- R1: `mdc` is low after reset and runs freely. With H = floor(max(divider,2)/2), it toggles once every H host cycles, so its period is 2·H cycles. Divider values 0 and 1 behave like 2.
- R2: A write frame is sent MSB first, with each bit held for one MDC period. The bits are: 32 ones (the preamble), start `01`, opcode `01`, 5-bit PHY address, 5-bit register address, turnaround `10`, then the 16 data bits. `mdio_out` and `mdio_oe` change only on the host cycle in which `mdc` falls.
- R3: A read frame, or a scan frame, sends opcode `10`. For the two turnaround bits and the 16 data bits, `mdio_oe` is low and `mdio_out` is 0. Each data bit is sampled from `mdio_in` on the host cycle in which `mdc` rises.
- R4: When a write frame starts, `wr_start` is high for exactly one cycle. When a read frame starts, `rd_start` is high for exactly one cycle. A scan frame produces neither pulse.
- R5: On the `mdc` falling edge that ends a read or scan frame, `rd_data` takes the 16 sampled bits (first sampled bit = bit 15), and `rd_valid` is high for one cycle.
- R6: `busy` goes high on the falling edge that starts a frame and goes low only on a falling edge where one frame ends and no request is pending. A following frame starts on that same falling edge, so `busy` does not drop between frames. While `busy` is low, `mdio_oe` is low.
- R7: Requests are sampled on a falling edge while idle or while a frame ends. Write wins over read, and read wins over scan.
- R8: While the scan request is held, the block reads the addressed register back-to-back with no start pulses.
- R9: When a read or scan of register address 1 completes, `link_fail` becomes the inverse of bit 2 of the read value. A completed read of any other address leaves `link_fail` unchanged.
- R10: `scan_invalid` rises when the first scan frame of a run starts and falls when a scan frame completes. A run is broken by any other frame or by an idle slot.
- R11: With `no_preamble` high, frames omit the 32 preamble bits and last 32 MDC periods instead of 64.
- R12: During and right after reset, `mdc`, `mdio_out`, `mdio_oe`, `busy`, both start pulses, `rd_valid`, `rd_data`, `link_fail` and `scan_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divider | input | DIV_W | MDC divider; period is 2·floor(max(divider,2)/2) host cycles |
| no_preamble | input | 1 | Omit the 32-bit preamble |
| req_write | input | 1 | Write-register request (level) |
| req_read | input | 1 | Read-register request (level) |
| req_scan | input | 1 | Continuous scan request (level) |
| phy_addr | input | 5 | PHY address used for the next frame |
| reg_addr | input | 5 | Register address used for the next frame |
| wr_data | input | 16 | Value for a write frame |
| wr_start | output | 1 | One-cycle pulse when a write frame starts |
| rd_start | output | 1 | One-cycle pulse when a read frame starts |
| busy | output | 1 | A frame is in progress |
| rd_data | output | 16 | Last value read from the PHY |
| rd_valid | output | 1 | One-cycle capture strobe for `rd_data` |
| link_fail | output | 1 | Inverse of link bit from register 1 |
| scan_invalid | output | 1 | Scan result not yet refreshed |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input value |

## Verification
On every cycle, the embedded assertions check the following: the line moves only after a falling MDC edge, the line is released during read turnaround and data and whenever the block is idle, each start pulse comes with `busy`, the read strobe never lasts two cycles, `link_fail` changes only as a frame completes, and `scan_invalid` is set only inside a scan run. Other behaviour only the bench's scenarios can show: the exact bit order of each frame, the divider clamp at small values, write-over-read-over-scan ordering when all three requests arrive together, the preamble-free frame length, and the link and invalid flags across scans of different registers. These are compared against a behavioural model every cycle.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared types and frame constants for the management master.
// Assumes frame positions are counted 0..63 over a full frame with preamble.
package mdio_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_SCAN  = 2'd3
    } mdio_op_e;

    localparam int          DATA_BITS = 16;
    localparam int          ADDR_BITS = 5;
    localparam logic [5:0]  IDX_NOPRE = 6'd32;   // first bit after preamble
    localparam logic [5:0]  IDX_TA    = 6'd46;   // first turnaround bit
    localparam logic [5:0]  IDX_DATA  = 6'd48;   // first data bit
    localparam logic [5:0]  IDX_LAST  = 6'd63;   // final data bit

    // Build the 64-bit frame image, MSB sent first.
    function automatic logic [63:0] build_frame(
        input mdio_op_e               op,
        input logic [ADDR_BITS-1:0]   phy,
        input logic [ADDR_BITS-1:0]   rg,
        input logic [DATA_BITS-1:0]   wd
    );
        logic is_wr;
        is_wr = (op == OP_WRITE);
        build_frame = {32'hFFFF_FFFF, 2'b01,
                       (is_wr ? 2'b01 : 2'b10),
                       phy, rg,
                       (is_wr ? 2'b10 : 2'b00),
                       (is_wr ? wd : {DATA_BITS{1'b0}})};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
// Module: mdio_clkgen
// Makes the free-running management clock from the host clock and flags
// the host cycle on which it will rise or fall.
// Assumes the divider is held steady except around reset.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divider,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] hcnt;
    logic             toggle;

    // Clamp divider and derive the half-period length.
    always_comb begin
        div_eff = (divider < MIN_DIV) ? MIN_DIV : divider;
        half    = div_eff >> 1;
        toggle  = (hcnt >= half - ONE);
        rise_evt = toggle & ~mdc;
        fall_evt = toggle & mdc;
    end

    // Count host cycles in each half period and flip the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            mdc  <= 1'b0;
        end else if (toggle) begin
            hcnt <= '0;
            mdc  <= ~mdc;
        end else begin
            hcnt <= hcnt + ONE;
        end
    end

    assert_fall_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !mdc);
    assert_rise_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> mdc);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_evt && !fall_evt) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
// Module: mdio_frame_seq
// Picks the next request at a frame slot, shifts the frame out on falling
// MDC edges, samples read data on rising edges and reports start/end.
// Assumes mdio_in is already synchronous to clk.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_evt,
    input  logic                 fall_evt,
    input  logic                 req_write,
    input  logic                 req_read,
    input  logic                 req_scan,
    input  logic                 no_preamble,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 mdio_in,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic                 busy,
    output logic                 wr_start,
    output logic                 rd_start,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 start_now,
    output mdio_op_e             start_op,
    output logic                 done_now,
    output mdio_op_e             done_op,
    output logic [ADDR_BITS-1:0] done_reg,
    output logic [DATA_BITS-1:0] rx_data
);
    logic                 active;
    mdio_op_e             cur_op;
    logic [ADDR_BITS-1:0] cur_reg;
    logic [5:0]           idx;
    logic [5:0]           nidx;
    logic [5:0]           first_idx;
    logic [63:0]          frame_q;
    logic [63:0]          new_frame;
    logic [DATA_BITS-1:0] rx_shift;
    logic                 slot_free;

    // Fixed-priority choice among pending requests.
    always_comb begin
        if (req_write)      start_op = OP_WRITE;
        else if (req_read)  start_op = OP_READ;
        else if (req_scan)  start_op = OP_SCAN;
        else                start_op = OP_NONE;
    end

    // Slot timing, next position and the image of a new frame.
    always_comb begin
        nidx      = idx + 6'd1;
        first_idx = no_preamble ? IDX_NOPRE : 6'd0;
        done_now  = fall_evt & active & (idx == IDX_LAST);
        slot_free = fall_evt & (~active | (idx == IDX_LAST));
        start_now = slot_free & (start_op != OP_NONE);
        new_frame = build_frame(start_op, phy_addr, reg_addr, wr_data);
        done_op   = cur_op;
        done_reg  = cur_reg;
        rx_data   = rx_shift;
        busy      = active;
    end

    // Frame state, line drive, read capture and one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cur_op   <= OP_NONE;
            cur_reg  <= '0;
            idx      <= '0;
            frame_q  <= '0;
            rx_shift <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            wr_start <= 1'b0;
            rd_start <= 1'b0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_start <= 1'b0;
            rd_start <= 1'b0;
            rd_valid <= 1'b0;
            if (rise_evt && active && (cur_op != OP_WRITE) && (idx >= IDX_DATA))
                rx_shift <= {rx_shift[DATA_BITS-2:0], mdio_in};
            if (done_now && (cur_op != OP_WRITE)) begin
                rd_data  <= rx_shift;
                rd_valid <= 1'b1;
            end
            if (slot_free) begin
                if (start_now) begin
                    active   <= 1'b1;
                    cur_op   <= start_op;
                    cur_reg  <= reg_addr;
                    frame_q  <= new_frame;
                    idx      <= first_idx;
                    mdio_out <= new_frame[6'd63 - first_idx];
                    mdio_oe  <= 1'b1;
                    wr_start <= (start_op == OP_WRITE);
                    rd_start <= (start_op == OP_READ);
                end else begin
                    active   <= 1'b0;
                    cur_op   <= OP_NONE;
                    mdio_out <= 1'b0;
                    mdio_oe  <= 1'b0;
                end
            end else if (fall_evt && active) begin
                idx      <= nidx;
                mdio_out <= frame_q[6'd63 - nidx];
                mdio_oe  <= (cur_op == OP_WRITE) || (nidx < IDX_TA);
            end
        end
    end

    assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_evt) |-> ($stable(mdio_out) && $stable(mdio_oe)));
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (cur_op != OP_WRITE) && (idx >= IDX_TA)) |-> !mdio_oe);
    assert_pulse_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start || rd_start) |-> busy);
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

endmodule

// File: rtl/mdio_status.sv
`timescale 1ns/1ps
// Module: mdio_status
// Tracks link failure from completed reads of the link register and the
// invalid qualifier across a run of scan frames.
// Assumes start and done flags are only high on falling MDC slots.
module mdio_status
    import mdio_pkg::*;
#(
    parameter logic [ADDR_BITS-1:0] LINK_REG = 5'd1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_now,
    input  mdio_op_e             start_op,
    input  logic                 done_now,
    input  mdio_op_e             done_op,
    input  logic [ADDR_BITS-1:0] done_reg,
    input  logic                 link_bit,
    output logic                 link_fail,
    output logic                 scan_invalid
);
    logic scan_run;

    // Update link state and scan qualifier at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_fail    <= 1'b0;
            scan_invalid <= 1'b0;
            scan_run     <= 1'b0;
        end else begin
            if (done_now && (done_op != OP_WRITE) && (done_reg == LINK_REG))
                link_fail <= ~link_bit;
            if (done_now && (done_op == OP_SCAN))
                scan_invalid <= 1'b0;
            if (start_now) begin
                scan_run <= (start_op == OP_SCAN);
                if ((start_op == OP_SCAN) && !scan_run)
                    scan_invalid <= 1'b1;
            end else if (done_now) begin
                scan_run <= 1'b0;
            end
        end
    end

    assert_link_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_now) |-> $stable(link_fail));
    assert_invalid_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_invalid |-> scan_run);

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Module: mdio_master
// Top of the serial management master: clock generator, frame sequencer
// and status tracker. The pad cell and host register file live outside.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int              DIV_W    = 8,
    parameter logic [4:0]      LINK_REG = 5'd1,
    parameter int              LINK_BIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divider,
    input  logic             no_preamble,
    input  logic             req_write,
    input  logic             req_read,
    input  logic             req_scan,
    input  logic [4:0]       phy_addr,
    input  logic [4:0]       reg_addr,
    input  logic [15:0]      wr_data,
    output logic             wr_start,
    output logic             rd_start,
    output logic             busy,
    output logic [15:0]      rd_data,
    output logic             rd_valid,
    output logic             link_fail,
    output logic             scan_invalid,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in
);
    logic                 rise_evt;
    logic                 fall_evt;
    logic                 start_now;
    mdio_op_e             start_op;
    logic                 done_now;
    mdio_op_e             done_op;
    logic [ADDR_BITS-1:0] done_reg;
    logic [DATA_BITS-1:0] rx_data;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .divider  (divider),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .req_write   (req_write),
        .req_read    (req_read),
        .req_scan    (req_scan),
        .no_preamble (no_preamble),
        .phy_addr    (phy_addr),
        .reg_addr    (reg_addr),
        .wr_data     (wr_data),
        .mdio_in     (mdio_in),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe),
        .busy        (busy),
        .wr_start    (wr_start),
        .rd_start    (rd_start),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .start_now   (start_now),
        .start_op    (start_op),
        .done_now    (done_now),
        .done_op     (done_op),
        .done_reg    (done_reg),
        .rx_data     (rx_data)
    );

    mdio_status #(.LINK_REG(LINK_REG)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_now    (start_now),
        .start_op     (start_op),
        .done_now     (done_now),
        .done_op      (done_op),
        .done_reg     (done_reg),
        .link_bit     (rx_data[LINK_BIT]),
        .link_fail    (link_fail),
        .scan_invalid (scan_invalid)
    );

    assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_start && rd_start));

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design every cycle.
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  divider = 8'd4;
    logic        no_preamble = 1'b0;
    logic        req_write = 1'b0;
    logic        req_read = 1'b0;
    logic        req_scan = 1'b0;
    logic [4:0]  phy_addr = 5'd3;
    logic [4:0]  reg_addr = 5'd9;
    logic [15:0] wr_data = 16'hA5C3;
    logic        mdio_in = 1'b0;
    logic        wr_start, rd_start, busy, rd_valid, link_fail, scan_invalid;
    logic        mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int wd = 0;
    logic [15:0] phy_mem [32];
    int ev[$];

    always #2.5 clk = ~clk;

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .divider(divider), .no_preamble(no_preamble),
        .req_write(req_write), .req_read(req_read), .req_scan(req_scan),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .wr_start(wr_start), .rd_start(rd_start), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail),
        .scan_invalid(scan_invalid), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // {out, oe} for frame position p
    function automatic bit [1:0] fbit(int p, int op, logic [4:0] pa, logic [4:0] ra, logic [15:0] wv);
        if (p < 32)  return 2'b11;
        if (p == 32) return 2'b01;
        if (p == 33) return 2'b11;
        if (p == 34) return (op == 1) ? 2'b01 : 2'b11;
        if (p == 35) return (op == 1) ? 2'b11 : 2'b01;
        if (p <= 40) return {pa[40-p], 1'b1};
        if (p <= 45) return {ra[45-p], 1'b1};
        if (op != 1) return 2'b00;
        if (p == 46) return 2'b11;
        if (p == 47) return 2'b01;
        return {wv[63-p], 1'b1};
    endfunction

    // Reference model state
    int       n_cyc = 0;
    int       m_pos = 0;
    int       m_op = 0;
    int       m_reg = 0;
    bit       m_active = 0;
    bit       m_run = 0;
    bit [1:0] q[$];
    logic     e_mdc = 0, e_out = 0, e_oe = 0, e_busy = 0, e_wrs = 0, e_rds = 0;
    logic     e_valid = 0, e_link = 0, e_nv = 0;
    logic [15:0] e_rdata = 0;

    always @(posedge clk) begin : model
        int h;
        int op;
        int st;
        bit fall;
        bit [1:0] tmp;
        if (!rst_n) begin
            n_cyc = 0; m_pos = 0; m_op = 0; m_reg = 0; m_active = 0; m_run = 0;
            q.delete();
            e_mdc = 0; e_out = 0; e_oe = 0; e_busy = 0; e_wrs = 0; e_rds = 0;
            e_valid = 0; e_link = 0; e_nv = 0; e_rdata = 0;
        end else begin
            n_cyc++;
            h = ((divider < 2) ? 2 : int'(divider)) / 2;
            fall = (n_cyc % h == 0) && ((n_cyc / h) % 2 == 0);
            e_mdc = ((n_cyc / h) % 2 == 1);
            e_wrs = 0; e_rds = 0; e_valid = 0;
            if (fall) begin
                if (!m_active || q.size() == 0) begin
                    if (m_active && m_op != 1) begin
                        e_rdata = phy_mem[m_reg];
                        e_valid = 1;
                        if (m_reg == 1) e_link = ~phy_mem[m_reg][2];
                        if (m_op == 3) e_nv = 0;
                    end
                    op = req_write ? 1 : req_read ? 2 : req_scan ? 3 : 0;
                    if (op != 0) begin
                        if (op == 3 && !m_run) e_nv = 1;
                        m_run = (op == 3);
                        st = no_preamble ? 32 : 0;
                        q.delete();
                        for (int p = st; p < 64; p++) q.push_back(fbit(p, op, phy_addr, reg_addr, wr_data));
                        tmp = q.pop_front();
                        e_out = tmp[1]; e_oe = tmp[0];
                        m_pos = st; m_active = 1; m_op = op; m_reg = int'(reg_addr);
                        e_wrs = (op == 1); e_rds = (op == 2);
                    end else begin
                        m_active = 0; m_op = 0; m_run = 0; e_out = 0; e_oe = 0;
                    end
                end else begin
                    tmp = q.pop_front();
                    e_out = tmp[1]; e_oe = tmp[0];
                    m_pos++;
                end
            end
            e_busy = m_active;
        end
    end

    // PHY responder and host request clearing
    always @(negedge clk) begin
        mdio_in = (m_active && m_op != 1 && m_pos >= 48) ? phy_mem[m_reg][63-m_pos] : 1'b0;
        if (wr_start) req_write = 1'b0;
        if (rd_start) req_read = 1'b0;
        if (wr_start) ev.push_back(1);
        if (rd_start) ev.push_back(2);
        if (rd_valid) ev.push_back(3);
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 mdc", 32'(mdc), 32'(e_mdc));
            chk("R2 mdio_out", 32'(mdio_out), 32'(e_out));
            chk("R3 mdio_oe", 32'(mdio_oe), 32'(e_oe));
            chk("R4 wr_start", 32'(wr_start), 32'(e_wrs));
            chk("R4 rd_start", 32'(rd_start), 32'(e_rds));
            chk("R5 rd_data", 32'(rd_data), 32'(e_rdata));
            chk("R5 rd_valid", 32'(rd_valid), 32'(e_valid));
            chk("R6 busy", 32'(busy), 32'(e_busy));
            chk("R9 link_fail", 32'(link_fail), 32'(e_link));
            chk("R10 scan_invalid", 32'(scan_invalid), 32'(e_nv));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", wd);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_reset(input logic [7:0] dv);
        @(negedge clk);
        rst_n = 1'b0;
        divider = dv;
        repeat (3) @(negedge clk);
        chk("R12 reset", {22'd0, mdc, mdio_out, mdio_oe, busy, wr_start, rd_start,
                          rd_valid, link_fail, scan_invalid, |rd_data}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic run_count(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            if (busy) cnt++;
        end while (req_write || req_read || busy || cnt == 0);
    endtask

    task automatic wait_strobes(input int k);
        int seen = 0;
        while (seen < k) begin
            @(negedge clk);
            if (rd_valid) seen++;
        end
    endtask

    initial begin
        int cnt;
        int rds;
        for (int r = 0; r < 32; r++) phy_mem[r] = 16'h1357 ^ (16'(r) * 16'h0911);
        phy_mem[1] = 16'h7869;     // link bit (bit 2) low

        // Write frame with preamble, divider 4
        do_reset(8'd4);
        @(negedge clk); req_write = 1'b1;
        run_count(cnt);
        chk("R2 write frame length", 32'(cnt), 32'd256);

        // Read without preamble
        @(negedge clk); no_preamble = 1'b1; reg_addr = 5'd5; req_read = 1'b1;
        run_count(cnt);
        chk("R11 short frame length", 32'(cnt), 32'd128);
        chk("R5 read value", 32'(rd_data), 32'(phy_mem[5]));

        // Divider clamp: 0 behaves as 2
        do_reset(8'd0);
        no_preamble = 1'b0; wr_data = 16'h3C5A; phy_addr = 5'd17;
        @(negedge clk); req_write = 1'b1;
        run_count(cnt);
        chk("R1 clamped divider frame length", 32'(cnt), 32'd128);

        // Priority with all three requests, divider 5, link register
        do_reset(8'd5);
        ev.delete();
        reg_addr = 5'd1; wr_data = 16'h0F0F;
        @(negedge clk); req_write = 1'b1; req_read = 1'b1; req_scan = 1'b1;
        wait_strobes(3);
        chk("R7 first start is write", 32'(ev[0]), 32'd1);
        chk("R7 second start is read", 32'(ev[1]), 32'd2);
        rds = 0;
        foreach (ev[i]) if (ev[i] == 2) rds++;
        chk("R8 no start pulse during scan", 32'(rds), 32'd1);
        chk("R9 link fail from register 1", 32'(link_fail), 32'd1);
        chk("R8 scan data", 32'(rd_data), 32'(phy_mem[1]));
        @(negedge clk); req_scan = 1'b0;
        run_count(cnt);

        // Scan another register: link unchanged; then register 1 with link up
        @(negedge clk); reg_addr = 5'd7; req_scan = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wait_strobes(1);
        chk("R9 other register keeps link", 32'(link_fail), 32'd1);
        @(negedge clk); req_scan = 1'b0;
        run_count(cnt);
        phy_mem[1] = 16'h786D;    // link bit high
        @(negedge clk); reg_addr = 5'd1; req_scan = 1'b1;
        wait_strobes(1);
        chk("R9 link restored", 32'(link_fail), 32'd0);
        chk("R10 invalid cleared", 32'(scan_invalid), 32'd0);
        @(negedge clk); req_scan = 1'b0;
        run_count(cnt);

        // Default divider value 100
        do_reset(8'd100);
        @(negedge clk); reg_addr = 5'd2; req_write = 1'b1;
        run_count(cnt);
        chk("R1 divider 100 frame length", 32'(cnt), 32'd6400);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule